// File: doc/BRIEF.md
# Serial Control Register Access Master

This block reads and writes 16-bit registers in a peripheral that has a serial control port on an SPI-style link. A user-side request gives the direction, an 8-bit register address and, for writes, 16 bits of data. The block then drives one four-byte frame with the select line held low. The first byte is an opcode (0x02 write, 0x03 read). The second byte is the address. The last two bytes carry the data, high byte first.

On a read the block shifts out zero bytes in the data positions. It assembles the result from the bytes the peripheral returns in the third and fourth positions. After the last bit, select is held low for a timed guard interval and then raised. A second guard interval must pass before the block reports completion with a one-cycle done pulse and accepts new work.

Top module: `ctrl_reg_master`

## Requirements
- R1: After reset, and whenever busy is low, cs_n is high, sck is low and done is low.
- R2: When req_valid is sampled high while busy is low, the request is accepted. At the next clock edge busy goes high and cs_n goes low. cs_n stays low for the whole frame.
- R3: A frame has exactly 32 rising sck edges and is sent MSB first in mode 0. sck idles low. mosi changes only after falling edges. miso is taken before each rising edge. Each sck high phase lasts DIV/2 clocks.
- R4: Byte 1 of the frame is 0x02 for a write (req_write=1) and 0x03 for a read (req_write=0). Byte 2 is req_addr.
- R5: On a write, byte 3 is req_wdata[15:8] and byte 4 is req_wdata[7:0].
- R6: On a read, bytes 3 and 4 on mosi are 0x00. rd_data becomes {miso byte 3, miso byte 4} by the time done is high.
- R7: After the last falling sck edge, cs_n stays low for GUARD_CYCLES to GUARD_CYCLES+3 clocks before it rises.
- R8: After cs_n rises, GUARD_CYCLES to GUARD_CYCLES+3 clocks pass before done goes high. done is high for exactly one cycle, and busy is low in that cycle.
- R9: A req_valid pulse while busy is high is ignored. It does not change the frame in progress and does not start another frame.
- R10: rd_data keeps its value through write transactions and changes only when a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | High from acceptance until done |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Result of the last read |
| cs_n | output | 1 | Active-low control select |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
Suppose the byte index or the latched request is wrong. The captured mosi frame then differs from the expected opcode, address and data pattern in the same transaction. Suppose the divider or bit counter is off. The rising-edge count or the sck high-phase width is wrong before cs_n rises. A faulty guard timer shows as a hold or gap count outside its window when that frame ends. A bad read-capture path shows as a wrong rd_data when done is high. Requests issued mid-frame confirm that the latched request cannot be overwritten, which would show as a second select fall or a corrupted frame.

// File: rtl/ctrl_reg_pkg.sv
package ctrl_reg_pkg;

    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 16;
    localparam int BYTE_W      = 8;
    localparam int FRAME_BYTES = 4;
    localparam int IDX_W       = $clog2(FRAME_BYTES);

    localparam logic [BYTE_W-1:0] OPC_WRITE = 8'h02;
    localparam logic [BYTE_W-1:0] OPC_READ  = 8'h03;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_HOLD,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    // Byte sent at a given frame position; data bytes are zero on reads.
    function automatic logic [BYTE_W-1:0] frame_byte(reg_req_t r, logic [IDX_W-1:0] idx);
        logic [BYTE_W-1:0] b;
        case (idx)
            2'd0:    b = r.wr ? OPC_WRITE : OPC_READ;
            2'd1:    b = r.addr;
            2'd2:    b = r.wr ? r.wdata[15:8] : '0;
            default: b = r.wr ? r.wdata[7:0]  : '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic          act_q;
    logic [CW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    tx_q;
    logic [7:0]    rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= 1'b0;
            div_q     <= '0;
            bit_q     <= '0;
            tx_q      <= '0;
            rx_q      <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!act_q) begin
                if (start) begin
                    act_q <= 1'b1;
                    tx_q  <= tx_byte;
                    div_q <= '0;
                    bit_q <= '0;
                end
            end else begin
                if (div_q == CW'(HALF - 1))
                    rx_q <= {rx_q[6:0], miso};
                if (div_q == CW'(DIV - 1)) begin
                    div_q <= '0;
                    if (bit_q == 3'd7) begin
                        act_q     <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        tx_q  <= {tx_q[6:0], 1'b0};
                    end
                end else begin
                    div_q <= div_q + CW'(1);
                end
            end
        end
    end

    assign sck     = act_q && (div_q >= CW'(HALF));
    assign mosi    = tx_q[7];
    assign rx_byte = rx_q;

    assert_byte_end_R3: assert property (@(posedge clk) disable iff (rst)
        byte_done |-> $past(act_q) && !sck);

endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            run_q   <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (load) begin
                cnt_q <= CW'(CYCLES - 1);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (cnt_q == '0) begin
                    run_q   <= 1'b0;
                    expired <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end
        end
    end

    assert_expire_from_run_R7: assert property (@(posedge clk) disable iff (rst)
        expired |-> $past(run_q));

endmodule

// File: rtl/ctrl_reg_master.sv
module ctrl_reg_master
    import ctrl_reg_pkg::*;
#(
    parameter int DIV          = 4,
    parameter int GUARD_CYCLES = 1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        cs_n,
    output logic        sck,
    output logic        mosi,
    input  logic        miso
);
    seq_state_e       st_q;
    reg_req_t         req_q;
    reg_req_t         req_in;
    logic [IDX_W-1:0] idx_q;
    logic [15:0]      rd_q;
    logic             cs_n_q;
    logic             done_q;

    logic             accept;
    logic             last_byte;
    logic             eng_start;
    logic [7:0]       eng_tx;
    logic             eng_done;
    logic [7:0]       eng_rx;
    logic             tmr_load;
    logic             tmr_exp;

    assign req_in    = '{wr: req_write, addr: req_addr, wdata: req_wdata};
    assign accept    = (st_q == ST_IDLE) && req_valid;
    assign last_byte = (idx_q == IDX_W'(FRAME_BYTES - 1));
    assign eng_start = accept || ((st_q == ST_SHIFT) && eng_done && !last_byte);
    assign eng_tx    = accept ? frame_byte(req_in, '0)
                              : frame_byte(req_q, IDX_W'(idx_q + IDX_W'(1)));
    assign tmr_load  = ((st_q == ST_SHIFT) && eng_done && last_byte)
                    || ((st_q == ST_HOLD) && tmr_exp);

    spi_byte_engine #(.DIV(DIV)) shifter_i (
        .clk       (clk),
        .rst       (rst),
        .start     (eng_start),
        .tx_byte   (eng_tx),
        .miso      (miso),
        .sck       (sck),
        .mosi      (mosi),
        .byte_done (eng_done),
        .rx_byte   (eng_rx)
    );

    guard_timer #(.CYCLES(GUARD_CYCLES)) guard_i (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .expired (tmr_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            req_q  <= '0;
            idx_q  <= '0;
            rd_q   <= '0;
            cs_n_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q  <= req_in;
                        idx_q  <= '0;
                        cs_n_q <= 1'b0;
                        st_q   <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (eng_done) begin
                        if (!req_q.wr && idx_q == IDX_W'(2)) rd_q[15:8] <= eng_rx;
                        if (!req_q.wr && last_byte)          rd_q[7:0]  <= eng_rx;
                        if (last_byte) st_q  <= ST_HOLD;
                        else           idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (tmr_exp) begin
                        cs_n_q <= 1'b1;
                        st_q   <= ST_GAP;
                    end
                end
                default: begin
                    if (tmr_exp) begin
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    assign busy    = (st_q != ST_IDLE);
    assign done    = done_q;
    assign rd_data = rd_q;
    assign cs_n    = cs_n_q;

    assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n && !sck);
    assert_sck_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);
    assert_hold_selected_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_HOLD) |-> !cs_n && !sck);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_done_after_gap_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(cs_n) && $past(busy) && !busy);
    assert_req_locked_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(req_q));

endmodule

// File: tb/ctrl_reg_master_tb.sv
module ctrl_reg_master_tb_top;
    localparam int DIV   = 4;
    localparam int GUARD = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, cs_n, sck, mosi;
    logic [15:0] rd_data;
    logic        miso = 1'b0;

    always #2.5 clk = ~clk;

    ctrl_reg_master #(.DIV(DIV), .GUARD_CYCLES(GUARD)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Peripheral model and bus monitor, sampled away from the active edge.
    logic [15:0] slave_rd = '0;
    logic [31:0] got;
    int bits, hold_c, gap_c, hi_run, cs_falls, done_cnt;
    logic cs_p, sck_p, sck_bad;
    initial begin
        got = '0; bits = 0; hold_c = 0; gap_c = 0; hi_run = 0;
        cs_falls = 0; done_cnt = 0; cs_p = 1'b1; sck_p = 1'b0; sck_bad = 1'b0;
    end

    always @(negedge clk) begin
        logic [31:0] pat;
        pat = {16'h5AC3, slave_rd};
        if (!rst) begin
            if (cs_p && !cs_n) begin
                cs_falls++; bits = 0; got = '0; hold_c = 0; gap_c = 0; hi_run = 0;
                miso = pat[31];
            end
            if (!cs_n && sck && !sck_p) begin
                got = {got[30:0], mosi};
                bits++;
            end
            if (sck) hi_run = sck_p ? hi_run + 1 : 1;
            if (!cs_n && !sck && sck_p) begin
                if (hi_run != DIV / 2) sck_bad = 1'b1;
                if (bits < 32) miso = pat[31 - bits];
            end
            if (!cs_n && bits == 32 && !sck) hold_c++;
            if (cs_n && busy) gap_c++;
            if (done) done_cnt++;
        end
        cs_p  = cs_n;
        sck_p = sck;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_txn(input logic wr, input logic [7:0] a, input logic [15:0] wd,
                           input logic [15:0] rv, input bit poke);
        int falls0;
        int dones0;
        int waitc;
        logic [15:0] prev;
        logic [31:0] exp_frame;
        falls0 = cs_falls;
        dones0 = done_cnt;
        prev   = rd_data;
        exp_frame = {(wr ? 8'h02 : 8'h03), a, (wr ? wd : 16'h0000)};
        slave_rd = rv;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy && !cs_n, "R2 accept", {30'd0, busy, cs_n}, 32'h2);
        if (poke) begin
            repeat (20) @(negedge clk);
            req_valid = 1'b1; req_write = !wr; req_addr = ~a; req_wdata = ~wd;
            @(negedge clk);
            req_valid = 1'b0;
        end
        waitc = 0;
        while (!done && waitc < 5000) begin
            @(negedge clk);
            waitc++;
        end
        check(done && !busy, "R8 done with busy low", {30'd0, done, busy}, 32'h2);
        check(got == exp_frame, wr ? "R4 R5 write frame" : "R4 R6 read frame", got, exp_frame);
        check(bits == 32, "R3 rising edge count", bits, 32);
        check(!sck_bad, "R3 sck high phase width", {31'd0, sck_bad}, 0);
        check(hold_c >= GUARD && hold_c <= GUARD + 3, "R7 select hold", hold_c, GUARD);
        check(gap_c >= GUARD && gap_c <= GUARD + 3, "R8 deselect gap", gap_c, GUARD);
        if (wr) check(rd_data == prev, "R10 rd_data kept", {16'd0, rd_data}, {16'd0, prev});
        else    check(rd_data == rv, "R6 read data", {16'd0, rd_data}, {16'd0, rv});
        repeat (GUARD + 40) @(negedge clk);
        check(done_cnt - dones0 == 1, "R8 R9 one done pulse", done_cnt - dones0, 1);
        check(cs_falls - falls0 == 1, "R9 one frame only", cs_falls - falls0, 1);
        check(cs_n && !busy && !sck, "R1 idle after frame", {29'd0, cs_n, busy, sck}, 32'h4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cs_n && !busy && !done && !sck, "R1 reset state",
              {28'd0, cs_n, busy, done, sck}, 32'h8);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(cs_n && !busy && !done && !sck, "R1 idle after reset",
              {28'd0, cs_n, busy, done, sck}, 32'h8);
        run_txn(1'b0, 8'h00, 16'h0000, 16'hFFFF, 1'b0);
        run_txn(1'b1, 8'hFF, 16'hFFFF, 16'h0000, 1'b0);
        for (int i = 0; i < 6; i++) begin
            run_txn(1'b1, 8'(i * 37 + 1), 16'h1234 ^ 16'(i * 16'h1111), 16'(i), i[0]);
            run_txn(1'b0, 8'hF0 - 8'(i * 13), 16'h0, 16'hBEEF + 16'(i * 16'h0101), !i[0]);
        end
        run_txn(1'b0, 8'h0B, 16'h0, 16'h0000, 1'b1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(500000);
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

endmodule